// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests for a CPU and passes on one request at a time. Maskable requests come from an active-low external level pin and from a row of on-chip peripheral request lines. Two non-maskable events are latched as pending flags: a falling edge on an external non-maskable pin and a one-cycle pulse from the illegal-opcode detector.

Each cycle the block picks a winner in a fixed order. The illegal-opcode event comes first, then the non-maskable pin, then the maskable sources. Maskable sources take part only while the CPU's global mask bit is clear. A single priority-select register names one maskable source that is lifted above all the other maskable sources. The remaining maskable sources are ranked by index, lowest first.

The winner is frozen and presented to the CPU as a request line together with that source's own 16-bit vector address. The request and vector stay unchanged until the CPU acknowledges. The acknowledge releases the request and clears the pending flag of the source that was served, if that source is edge-type. Instruction fetch and stacking are done by the CPU, not by this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, cpu_req_o is 0 and the priority-select register holds 0, which selects the external maskable pin.
- R2: While the mask input is 0 and cpu_req_o is 0, a maskable request that is present at a clock edge raises cpu_req_o after that edge.
- R3: While mask_i is 1, no maskable request raises cpu_req_o.
- R4: Without promotion, maskable sources are ranked by index, lowest first. Index 0 is the external pin (irq_n_i low). Index m (m ≥ 1) is periph_req_i[m-1].
- R5: Writing a value below NUM_MSK with prio_we_i stores it in the priority-select register. The maskable source with that index then outranks every other maskable source. A written value of NUM_MSK or more is ignored, and the stored value is kept.
- R6: A falling edge on nmi_n_i sets a pending flag regardless of mask_i. cpu_req_o rises two edges after the input falls. A pin that stays low does not trigger again after the flag is served.
- R7: A one-cycle illop_i pulse sets a pending flag regardless of mask_i. This flag outranks a pending non-maskable pin event, and both outrank every maskable source.
- R8: While cpu_req_o is 1, cpu_vec_o and cpu_req_o stay unchanged until cpu_ack_i is sampled high, even if a higher-ranked request arrives.
- R9: An acknowledge sampled with cpu_req_o high drops cpu_req_o after that edge. It clears only the served source's edge pending flag. A new non-maskable pin edge that arrives at the same edge as the acknowledge stays pending. Arbitration resumes one cycle after the drop.
- R10: cpu_vec_o equals VEC_TOP − 2·id. The id is 0 for the illegal-opcode event, 1 for the non-maskable pin and 2+m for maskable index m. With the default VEC_TOP = 16'hFFFE, maskable index 7 gives 16'hFFEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n_i | input | 1 | External maskable request, active-low level (maskable index 0) |
| periph_req_i | input | NUM_MSK-1 | Peripheral level requests; bit k is maskable index k+1 |
| nmi_n_i | input | 1 | External non-maskable pin, taken on a falling edge |
| illop_i | input | 1 | Illegal-opcode pulse, non-maskable |
| mask_i | input | 1 | Global interrupt mask bit from the CPU; 1 blocks maskable sources |
| prio_we_i | input | 1 | Write strobe for the priority-select register |
| prio_sel_i | input | SELW | Maskable index to promote |
| cpu_req_o | output | 1 | Interrupt request to the CPU |
| cpu_vec_o | output | 16 | Vector address of the held winner |
| cpu_ack_i | input | 1 | CPU acknowledge of the held request |

## Verification
- A maskable level request is due one edge after it is applied.
- An edge-type event is due two edges after it is applied: one edge to latch the pending flag and one to arbitrate.
- After an acknowledge, cpu_req_o is low one edge later, and the next winner appears one edge after that.

The bench drives every input on the falling clock edge and samples on a later falling edge, so each check lands exactly on the cycle where its result is due. Hold tests keep sampling over several cycles after a higher-ranked event, to show that nothing moves before the acknowledge.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int ID_ILLOP    = 0;
    localparam int ID_NMI      = 1;
    localparam int ID_MSK_BASE = 2;

    function automatic logic [15:0] vec_of(input logic [15:0] top, input int id);
        return top - 16'(2 * id);
    endfunction

endpackage

// File: rtl/ipc_evt_latch.sv
module ipc_evt_latch #(
    parameter bit FALL_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o
);

    logic set;
    logic pend_d, pend_q;

    generate
        if (FALL_EDGE) begin : g_fall
            logic prev_d, prev_q;
            always_comb prev_d = evt_i;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b1;
                else        prev_q <= prev_d;
            end
            assign set = prev_q & ~evt_i;
        end else begin : g_pulse
            assign set = evt_i;
        end
    endgenerate

    // a new event wins over a clear in the same cycle
    always_comb pend_d = set | (pend_q & ~clr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R6 / R7: an event is never lost
    a_r6_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pend_o);

    // R9: a clear without a new event removes the flag
    a_r9_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set) |=> !pend_o);

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter  int NUM_MSK = 18,
    localparam int SELW    = $clog2(NUM_MSK),
    localparam int IDW     = $clog2(NUM_MSK + 2)
) (
    input  logic               ill_pend_i,
    input  logic               nmi_pend_i,
    input  logic [NUM_MSK-1:0] req_i,
    input  logic               mask_i,
    input  logic [SELW-1:0]    prio_i,
    output logic               vld_o,
    output logic [IDW-1:0]     id_o
);

    logic            lo_hit;
    logic [SELW-1:0] lo_idx;

    always_comb begin
        lo_hit = 1'b0;
        lo_idx = '0;
        for (int i = NUM_MSK - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                lo_hit = 1'b1;
                lo_idx = SELW'(i);
            end
        end
    end

    always_comb begin
        vld_o = 1'b1;
        id_o  = '0;
        if (ill_pend_i) begin
            id_o = IDW'(ID_ILLOP);
        end else if (nmi_pend_i) begin
            id_o = IDW'(ID_NMI);
        end else if (!mask_i && req_i[prio_i]) begin
            id_o = IDW'(ID_MSK_BASE) + IDW'(prio_i);
        end else if (!mask_i && lo_hit) begin
            id_o = IDW'(ID_MSK_BASE) + IDW'(lo_idx);
        end else begin
            vld_o = 1'b0;
        end
    end

    // R4: a chosen maskable source is really requesting
    always_comb begin
        if (vld_o && !ill_pend_i && !nmi_pend_i)
            a_r4_pick_live: assert (req_i[int'(id_o) - ID_MSK_BASE]);
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter  int          NUM_MSK = 18,
    parameter  logic [15:0] VEC_TOP = 16'hFFFE,
    localparam int          SELW    = $clog2(NUM_MSK),
    localparam int          IDW     = $clog2(NUM_MSK + 2),
    localparam int          NPER    = NUM_MSK - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_n_i,
    input  logic [NPER-1:0] periph_req_i,
    input  logic            nmi_n_i,
    input  logic            illop_i,
    input  logic            mask_i,
    input  logic            prio_we_i,
    input  logic [SELW-1:0] prio_sel_i,
    output logic            cpu_req_o,
    output logic [15:0]     cpu_vec_o,
    input  logic            cpu_ack_i
);

    typedef struct packed {
        logic            busy;
        logic [IDW-1:0]  win;
        logic [SELW-1:0] prio;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_MSK-1:0] msk_req;
    logic               ill_pend, nmi_pend;
    logic               ill_clr, nmi_clr;
    logic               served;
    logic               arb_vld;
    logic [IDW-1:0]     arb_id;

    assign msk_req = {periph_req_i, ~irq_n_i};
    assign served  = ctl_q.busy & cpu_ack_i;
    assign ill_clr = served && (ctl_q.win == IDW'(ID_ILLOP));
    assign nmi_clr = served && (ctl_q.win == IDW'(ID_NMI));

    ipc_evt_latch #(.FALL_EDGE(1'b0)) u_ill (
        .clk(clk), .rst_n(rst_n), .evt_i(illop_i), .clr_i(ill_clr), .pend_o(ill_pend)
    );

    ipc_evt_latch #(.FALL_EDGE(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .evt_i(nmi_n_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
    );

    ipc_arbiter #(.NUM_MSK(NUM_MSK)) u_arb (
        .ill_pend_i(ill_pend),
        .nmi_pend_i(nmi_pend),
        .req_i     (msk_req),
        .mask_i    (mask_i),
        .prio_i    (ctl_q.prio),
        .vld_o     (arb_vld),
        .id_o      (arb_id)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (prio_we_i && (int'(prio_sel_i) < NUM_MSK))
            ctl_d.prio = prio_sel_i;
        if (served) begin
            ctl_d.busy = 1'b0;
        end else if (!ctl_q.busy && arb_vld) begin
            ctl_d.busy = 1'b1;
            ctl_d.win  = arb_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{busy: 1'b0, win: '0, prio: '0};
        else        ctl_q <= ctl_d;
    end

    assign cpu_req_o = ctl_q.busy;
    assign cpu_vec_o = vec_of(VEC_TOP, int'(ctl_q.win));

    // R8: request and vector frozen until acknowledge
    a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && !cpu_ack_i) |=> (cpu_req_o && $stable(cpu_vec_o)));

    // R9: acknowledge drops the request
    a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_o && cpu_ack_i) |=> !cpu_req_o);

    // R3: a maskable winner only when the mask was clear
    a_r3_mask_block: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_q.busy) && (ctl_q.win >= IDW'(ID_MSK_BASE))) |-> !$past(mask_i));

    // R7: a pending illegal-opcode event always wins
    a_r7_ill_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_q.busy) && $past(ill_pend)) |-> (ctl_q.win == IDW'(ID_ILLOP)));

    // R5: the promoted index is always a valid maskable source
    a_r5_prio_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ctl_q.prio) < NUM_MSK);

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

    localparam int NUM_MSK = 18;
    localparam int SELW    = $clog2(NUM_MSK);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               irq_n = 1'b1;
    logic [NUM_MSK-2:0] periph = '0;
    logic               nmi_n = 1'b1;
    logic               illop = 1'b0;
    logic               mask = 1'b0;
    logic               we = 1'b0;
    logic [SELW-1:0]    sel = '0;
    logic               req;
    logic [15:0]        vec;
    logic               ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl #(.NUM_MSK(NUM_MSK)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .periph_req_i(periph),
        .nmi_n_i(nmi_n), .illop_i(illop), .mask_i(mask), .prio_we_i(we),
        .prio_sel_i(sel), .cpu_req_o(req), .cpu_vec_o(vec), .cpu_ack_i(ack)
    );

    function automatic logic [15:0] ev(input int id);
        return 16'hFFFE - 16'(2 * id);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic quiesce();
        irq_n = 1'b1; periph = '0; illop = 1'b0; mask = 1'b0; we = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            if (req) do_ack();
        end
    endtask

    task automatic write_prio(input int v);
        we = 1'b1; sel = SELW'(v);
        cyc(1);
        we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req after reset", int'(req), 0);
    endtask

    task automatic t_basic();
        periph[6] = 1'b1;
        cyc(1);
        chk("R2 req one edge later", int'(req), 1);
        chk("R10 vector of index 7", int'(vec), int'(ev(9)));
        chk("R10 literal FFEC", int'(vec), 16'hFFEC);
        quiesce();
    endtask

    task automatic t_mask();
        mask = 1'b1; irq_n = 1'b0;
        cyc(3);
        chk("R3 masked stays idle", int'(req), 0);
        mask = 1'b0;
        cyc(1);
        chk("R3 unmask releases", int'(req), 1);
        chk("R3 pin vector", int'(vec), int'(ev(2)));
        quiesce();
    endtask

    task automatic t_order();
        irq_n = 1'b0; periph[0] = 1'b1; periph[9] = 1'b1;
        cyc(1);
        chk("R4 pin beats peripherals", int'(vec), int'(ev(2)));
        ack = 1'b1;
        cyc(1);
        ack = 1'b0; irq_n = 1'b1;
        chk("R9 req drops after ack", int'(req), 0);
        cyc(1);
        chk("R4 index 1 next", int'(vec), int'(ev(3)));
        quiesce();
    endtask

    task automatic t_promote();
        write_prio(12);
        irq_n = 1'b0; periph[0] = 1'b1; periph[11] = 1'b1;
        cyc(1);
        chk("R5 promoted index 12 wins", int'(vec), int'(ev(14)));
        quiesce();
        write_prio(25);
        irq_n = 1'b0; periph[11] = 1'b1;
        cyc(1);
        chk("R5 out-of-range write ignored", int'(vec), int'(ev(14)));
        quiesce();
        write_prio(0);
    endtask

    task automatic t_nmi();
        mask = 1'b1; periph[2] = 1'b1;
        nmi_n = 1'b0;
        cyc(1);
        chk("R6 not yet after one edge", int'(req), 0);
        cyc(1);
        chk("R6 nmi bypasses mask", int'(req), 1);
        chk("R6 nmi vector", int'(vec), int'(ev(1)));
        do_ack();
        cyc(3);
        chk("R6 low level no retrigger", int'(req), 0);
        nmi_n = 1'b1;
        quiesce();
    endtask

    task automatic t_ill();
        illop = 1'b1; nmi_n = 1'b0;
        cyc(1);
        illop = 1'b0; periph[0] = 1'b1;
        cyc(1);
        chk("R7 illegal opcode first", int'(vec), int'(ev(0)));
        do_ack();
        chk("R9 gap after ack", int'(req), 0);
        cyc(1);
        chk("R7 nmi kept and second", int'(vec), int'(ev(1)));
        do_ack();
        cyc(1);
        chk("R7 maskable last", int'(vec), int'(ev(3)));
        nmi_n = 1'b1;
        quiesce();
    endtask

    task automatic t_hold();
        periph[3] = 1'b1;
        cyc(1);
        chk("R8 maskable held", int'(vec), int'(ev(6)));
        nmi_n = 1'b0;
        cyc(3);
        chk("R8 req held", int'(req), 1);
        chk("R8 vector unchanged", int'(vec), int'(ev(6)));
        do_ack();
        cyc(1);
        chk("R8 nmi after ack", int'(vec), int'(ev(1)));
        nmi_n = 1'b1;
        cyc(1);
        nmi_n = 1'b0; ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        chk("R9 drop with new edge", int'(req), 0);
        cyc(1);
        chk("R9 new edge kept pending", int'(vec), int'(ev(1)));
        nmi_n = 1'b1;
        quiesce();
    endtask

    task automatic t_reset_prio();
        write_prio(5);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        periph[2] = 1'b1; periph[4] = 1'b1;
        cyc(1);
        chk("R1 promotion cleared by reset", int'(vec), int'(ev(5)));
        quiesce();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_basic();
        t_mask();
        t_order();
        t_promote();
        t_nmi();
        t_ill();
        t_hold();
        t_reset_prio();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule